// File: doc/BRIEF.md
# Processor-to-Bus Word Format Converter

This block sits between a 24-bit processor word port and a 32-bit bus data path and converts words in both directions. A 2-bit format code picks one of four layouts. In the packed half-word layout, two processor words share one bus word, 16 bits each. In the other three layouts, each processor word maps to exactly one bus word: right-aligned with zero extension, right-aligned with sign extension, or left-aligned with the low byte cleared.

The outbound path takes processor words and sends bus words. The inbound path takes bus words and sends processor words. All four data ports use a valid/ready handshake, and a transfer happens on a clock edge where both valid and ready are high. Software-side logic requests a new format with a one-cycle write strobe. The block applies the new code only if neither path holds any data. Otherwise it ignores the request and sets a sticky error flag.

Top module: `wfmt_conv`

## Requirements
- R1: While `rst_n` is low at a clock edge, the format code returns to 0, the error flag clears, and both paths empty. After reset `tx_bus_valid` and `rx_word_valid` are 0, and `tx_word_ready` and `rx_bus_ready` are 1.
- R2: With format 0, the first accepted processor word's bits 15:0 become bus bits 15:0 and the second word's bits 15:0 become bus bits 31:16. One bus word is produced per two processor words, and no bus word is produced after only one.
- R3: With format 1, a processor word goes out as a bus word with the word in bits 23:0 and bits 31:24 zero.
- R4: With format 2, a processor word goes out in bus bits 23:0, and bits 31:24 all equal word bit 23.
- R5: With format 3, a processor word goes out in bus bits 31:8, and bits 7:0 are zero.
- R6: With format 0, each inbound bus word yields two processor words. The first is bus bits 15:0 and the second is bus bits 31:16. Both have bits 23:16 zero.
- R7: With formats 1 and 2, an inbound bus word yields one processor word equal to bus bits 23:0. With format 3 the word is bus bits 31:8.
- R8: A format write (`cfg_wr` high) while both paths are empty loads `cfg_fmt`, and `fmt_cur` shows it from the next cycle. In the cycle `cfg_wr` is high, `tx_word_ready` and `rx_bus_ready` are 0.
- R9: A format write while either path holds data has no effect on `fmt_cur` and sets `fmt_err`. A half-filled pack counts as holding data. `fmt_err` stays 1 until reset.
- R10: An output whose valid is high and whose ready is low keeps valid high and its data unchanged in the next cycle, and no word is lost or repeated under backpressure.
- R11: An output word is valid in the cycle after the edge that completes it: the second packed word in format 0, or the single word otherwise, on the outbound side, and the accepted bus word on the inbound side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Format write strobe |
| cfg_fmt | input | 2 | Requested format code |
| fmt_cur | output | 2 | Format code in force |
| fmt_err | output | 1 | Sticky flag: a format write was refused |
| tx_word_valid | input | 1 | Outbound processor word valid |
| tx_word_ready | output | 1 | Outbound processor word accepted |
| tx_word_data | input | 24 | Outbound processor word |
| tx_bus_valid | output | 1 | Outbound bus word valid |
| tx_bus_ready | input | 1 | Bus side takes the outbound word |
| tx_bus_data | output | 32 | Outbound bus word |
| rx_bus_valid | input | 1 | Inbound bus word valid |
| rx_bus_ready | output | 1 | Inbound bus word accepted |
| rx_bus_data | input | 32 | Inbound bus word |
| rx_word_valid | output | 1 | Inbound processor word valid |
| rx_word_ready | input | 1 | Processor side takes the inbound word |
| rx_word_data | output | 24 | Inbound processor word |

## Verification
A bus word becomes valid one edge after the processor word that completes it is accepted. An inbound processor word becomes valid one edge after its bus word is accepted. A new format code shows one edge after the write strobe. The bench drives inputs on the falling edge and samples outputs 2 ns after it, so each handshake is judged on values that have settled for that coming rising edge. Directed checks look for the latency results exactly one falling edge after the accepting edge, and again while ready is held low to confirm the word stays put. Streams under random backpressure are compared in order against words computed by bench functions.

// File: rtl/wfmt_pkg.sv
// Package: shared format code type for the word format converter.
// Assumes a 2-bit code; values 0..3 select the four layouts.
package wfmt_pkg;
    typedef enum logic [1:0] {
        FMT_HALF16 = 2'd0,  // two 16-bit halves per bus word
        FMT_RZEXT  = 2'd1,  // right aligned, zero extended
        FMT_RSEXT  = 2'd2,  // right aligned, sign extended
        FMT_LFILL  = 2'd3   // left aligned, low bits zero
    } fmt_e;
endpackage

// File: rtl/wfmt_ctrl.sv
// Module: format code holder. Loads a new code only when both data paths
// are empty, and otherwise sets a sticky error. It raises stall during a
// write so that no transfer starts under a code that is about to change.
// Assumes cfg_wr is a single-cycle strobe from register logic.
module wfmt_ctrl
    import wfmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  fmt_e cfg_fmt,
    input  logic tx_idle,
    input  logic rx_idle,
    output fmt_e fmt,
    output logic err,
    output logic stall
);
    fmt_e fmt_q;
    logic err_q;
    logic both_idle;

    assign both_idle = tx_idle && rx_idle;
    assign stall     = cfg_wr;
    assign fmt       = fmt_q;
    assign err       = err_q;

    // Purpose: accept or refuse a format write and keep the sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q <= FMT_HALF16;
            err_q <= 1'b0;
        end else if (cfg_wr) begin
            if (both_idle) begin
                fmt_q <= cfg_fmt;
            end else begin
                err_q <= 1'b1;
            end
        end
    end

    // R8: the code moves only after a write seen while both paths were empty
    a_r8_change_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_q != $past(fmt_q)) |-> $past(cfg_wr && tx_idle && rx_idle));

    // R9: a refused write leaves the code alone and raises the flag
    a_r9_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !(tx_idle && rx_idle)) |=> (fmt_q == $past(fmt_q)) && err_q);

    // R9: the flag only clears at reset
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
endmodule

// File: rtl/wfmt_tx.sv
// Module: outbound path, processor words to bus words. In the half-word
// format it parks the low half of the first word and sends a bus word
// with the second. Otherwise it maps each word by alignment and
// extension. There is one registered output slot.
// Assumes BUS_W is even, BUS_W/2 <= WORD_W < BUS_W.
module wfmt_tx
    import wfmt_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fmt_e              fmt,
    input  logic              stall,
    input  logic              w_valid,
    output logic              w_ready,
    input  logic [WORD_W-1:0] w_data,
    output logic              b_valid,
    input  logic              b_ready,
    output logic [BUS_W-1:0]  b_data,
    output logic              idle
);
    localparam int HALF_W = BUS_W / 2;
    localparam int EXT_W  = BUS_W - WORD_W;

    logic              half_vld;
    logic [HALF_W-1:0] half_q;
    logic              out_vld;
    logic [BUS_W-1:0]  out_q;
    logic              slot_free;
    logic              is_pack;
    logic              accept;
    logic              emit;
    logic [BUS_W-1:0]  next_word;

    // Purpose: place a single word on the bus per the aligned formats.
    function automatic logic [BUS_W-1:0] map_word(input fmt_e f, input logic [WORD_W-1:0] w);
        logic [BUS_W-1:0] r;
        case (f)
            FMT_RZEXT: r = {{EXT_W{1'b0}}, w};
            FMT_RSEXT: r = {{EXT_W{w[WORD_W-1]}}, w};
            FMT_LFILL: r = {w, {EXT_W{1'b0}}};
            default:   r = '0;
        endcase
        return r;
    endfunction

    assign is_pack   = (fmt == FMT_HALF16);
    assign slot_free = !out_vld || b_ready;
    assign w_ready   = !stall && (is_pack ? (!half_vld || slot_free) : slot_free);
    assign accept    = w_valid && w_ready;
    assign emit      = accept && (!is_pack || half_vld);
    assign idle      = !out_vld && !half_vld;
    assign b_valid   = out_vld;
    assign b_data    = out_q;

    // Purpose: choose the bus word built from the incoming processor word.
    always_comb begin
        if (is_pack) begin
            next_word = {w_data[HALF_W-1:0], half_q};
        end else begin
            next_word = map_word(fmt, w_data);
        end
    end

    // Purpose: hold the parked first half in the half-word format.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_vld <= 1'b0;
            half_q   <= '0;
        end else if (accept && is_pack) begin
            half_vld <= !half_vld;
            if (!half_vld) begin
                half_q <= w_data[HALF_W-1:0];
            end
        end
    end

    // Purpose: fill the output slot on emit, empty it when the bus takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_q   <= '0;
        end else if (emit) begin
            out_vld <= 1'b1;
            out_q   <= next_word;
        end else if (b_ready) begin
            out_vld <= 1'b0;
        end
    end

    // R10: a stalled bus word stays valid and unchanged
    a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && !b_ready) |=> (b_valid && $stable(b_data)));

    // R11: a completing word shows on the bus one edge later
    a_r11_tx_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && w_ready && (!is_pack || half_vld)) |=> b_valid);

    // R2: a parked half exists only in the half-word format
    a_r2_half_only_pack: assert property (@(posedge clk) disable iff (!rst_n)
        half_vld |-> is_pack);

    // R3: zero-extended words carry no upper bits
    a_r3_tx_zext_top: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && fmt == FMT_RZEXT) |-> (b_data[BUS_W-1:WORD_W] == '0));

    // R4: sign-extended words repeat the word's top bit
    a_r4_tx_sext_top: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && fmt == FMT_RSEXT) |-> (b_data[BUS_W-1:WORD_W] == {EXT_W{b_data[WORD_W-1]}}));

    // R5: left-aligned words carry no low bits
    a_r5_tx_lfill_low: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && fmt == FMT_LFILL) |-> (b_data[EXT_W-1:0] == '0));
endmodule

// File: rtl/wfmt_rx.sv
// Module: inbound path, bus words to processor words. Holds one bus word.
// In the half-word format it sends the low half, then the high half.
// Otherwise it sends one word taken from the aligned field.
// Assumes the same width limits as the outbound path.
module wfmt_rx
    import wfmt_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fmt_e              fmt,
    input  logic              stall,
    input  logic              b_valid,
    output logic              b_ready,
    input  logic [BUS_W-1:0]  b_data,
    output logic              w_valid,
    input  logic              w_ready,
    output logic [WORD_W-1:0] w_data,
    output logic              idle
);
    localparam int HALF_W = BUS_W / 2;
    localparam int EXT_W  = BUS_W - WORD_W;
    localparam int PAD_W  = WORD_W - HALF_W;

    logic             hold_vld;
    logic [BUS_W-1:0] hold_q;
    logic             second;
    logic             last;
    logic             is_pack;

    assign is_pack = (fmt == FMT_HALF16);
    assign last    = !is_pack || second;
    assign b_ready = !stall && (!hold_vld || (w_ready && last));
    assign w_valid = hold_vld;
    assign idle    = !hold_vld;

    // Purpose: pick the processor word out of the held bus word.
    always_comb begin
        case (fmt)
            FMT_HALF16: w_data = second ? {{PAD_W{1'b0}}, hold_q[BUS_W-1:HALF_W]}
                                        : {{PAD_W{1'b0}}, hold_q[HALF_W-1:0]};
            FMT_LFILL:  w_data = hold_q[BUS_W-1:EXT_W];
            default:    w_data = hold_q[WORD_W-1:0];
        endcase
    end

    // Purpose: load a bus word, step through its halves, release it when done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld <= 1'b0;
            hold_q   <= '0;
            second   <= 1'b0;
        end else if (b_valid && b_ready) begin
            hold_vld <= 1'b1;
            hold_q   <= b_data;
            second   <= 1'b0;
        end else if (hold_vld && w_ready) begin
            if (last) begin
                hold_vld <= 1'b0;
                second   <= 1'b0;
            end else begin
                second   <= 1'b1;
            end
        end
    end

    // R10: a stalled processor word stays valid and unchanged
    a_r10_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && !w_ready) |=> (w_valid && $stable(w_data)));

    // R11: an accepted bus word yields a valid word one edge later
    a_r11_rx_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && b_ready) |=> w_valid);

    // R6: the second-half step exists only in the half-word format
    a_r6_second_only_pack: assert property (@(posedge clk) disable iff (!rst_n)
        second |-> (is_pack && hold_vld));

    // R6: after the first half is taken the second half follows
    a_r6_first_then_second: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_vld && is_pack && !second && w_ready && !b_valid) |=> (hold_vld && second));
endmodule

// File: rtl/wfmt_conv.sv
// Module: top of the 24/32-bit word format converter. Ties the format
// holder to the outbound and inbound paths. Assumes a single clock and
// synchronous active-low reset.
module wfmt_conv
    import wfmt_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_fmt,
    output logic [1:0]        fmt_cur,
    output logic              fmt_err,
    input  logic              tx_word_valid,
    output logic              tx_word_ready,
    input  logic [WORD_W-1:0] tx_word_data,
    output logic              tx_bus_valid,
    input  logic              tx_bus_ready,
    output logic [BUS_W-1:0]  tx_bus_data,
    input  logic              rx_bus_valid,
    output logic              rx_bus_ready,
    input  logic [BUS_W-1:0]  rx_bus_data,
    output logic              rx_word_valid,
    input  logic              rx_word_ready,
    output logic [WORD_W-1:0] rx_word_data
);
    fmt_e fmt;
    logic stall;
    logic tx_idle;
    logic rx_idle;

    assign fmt_cur = fmt;

    wfmt_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (cfg_wr),
        .cfg_fmt (fmt_e'(cfg_fmt)),
        .tx_idle (tx_idle),
        .rx_idle (rx_idle),
        .fmt     (fmt),
        .err     (fmt_err),
        .stall   (stall)
    );

    wfmt_tx #(.WORD_W(WORD_W), .BUS_W(BUS_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .fmt     (fmt),
        .stall   (stall),
        .w_valid (tx_word_valid),
        .w_ready (tx_word_ready),
        .w_data  (tx_word_data),
        .b_valid (tx_bus_valid),
        .b_ready (tx_bus_ready),
        .b_data  (tx_bus_data),
        .idle    (tx_idle)
    );

    wfmt_rx #(.WORD_W(WORD_W), .BUS_W(BUS_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .fmt     (fmt),
        .stall   (stall),
        .b_valid (rx_bus_valid),
        .b_ready (rx_bus_ready),
        .b_data  (rx_bus_data),
        .w_valid (rx_word_valid),
        .w_ready (rx_word_ready),
        .w_data  (rx_word_data),
        .idle    (rx_idle)
    );
endmodule

// File: tb/wfmt_conv_tb.sv
module wfmt_conv_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_fmt = 2'd0;
    logic [1:0]  fmt_cur;
    logic        fmt_err;
    logic        tx_word_valid = 1'b0;
    logic        tx_word_ready;
    logic [23:0] tx_word_data = '0;
    logic        tx_bus_valid;
    logic        tx_bus_ready = 1'b1;
    logic [31:0] tx_bus_data;
    logic        rx_bus_valid = 1'b0;
    logic        rx_bus_ready;
    logic [31:0] rx_bus_data = '0;
    logic        rx_word_valid;
    logic        rx_word_ready = 1'b1;
    logic [23:0] rx_word_data;

    int n_vec = 0;
    int n_bad = 0;
    int tx_rdy_mode = 0;   // 0 always ready, 1 random, 2 held low
    int rx_rdy_mode = 0;
    logic [31:0] tx_exp[$];
    logic [31:0] tx_got[$];
    logic [23:0] rx_exp[$];
    logic [23:0] rx_got[$];

    always #10 clk = ~clk;   // 50 MHz

    wfmt_conv u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_fmt(cfg_fmt),
        .fmt_cur(fmt_cur), .fmt_err(fmt_err),
        .tx_word_valid(tx_word_valid), .tx_word_ready(tx_word_ready), .tx_word_data(tx_word_data),
        .tx_bus_valid(tx_bus_valid), .tx_bus_ready(tx_bus_ready), .tx_bus_data(tx_bus_data),
        .rx_bus_valid(rx_bus_valid), .rx_bus_ready(rx_bus_ready), .rx_bus_data(rx_bus_data),
        .rx_word_valid(rx_word_valid), .rx_word_ready(rx_word_ready), .rx_word_data(rx_word_data)
    );

    function automatic logic [31:0] fmt_out(input logic [1:0] f, input logic [23:0] w);
        case (f)
            2'd1: return {8'h00, w};
            2'd2: return {{8{w[23]}}, w};
            2'd3: return {w, 8'h00};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] pack_out(input logic [23:0] w0, input logic [23:0] w1);
        return {w1[15:0], w0[15:0]};
    endfunction

    function automatic logic [23:0] fmt_in(input logic [1:0] f, input logic [31:0] b, input bit hi);
        case (f)
            2'd0: return hi ? {8'h00, b[31:16]} : {8'h00, b[15:0]};
            2'd3: return b[31:8];
            default: return b[23:0];
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // ready drivers, changed on falling edges
    always @(negedge clk) begin
        tx_bus_ready  = (tx_rdy_mode == 0) ? 1'b1 : (tx_rdy_mode == 1) ? (($urandom % 4) != 0) : 1'b0;
        rx_word_ready = (rx_rdy_mode == 0) ? 1'b1 : (rx_rdy_mode == 1) ? (($urandom % 3) != 0) : 1'b0;
    end

    // monitors: record handshakes that the coming rising edge completes
    logic        tx_prev_stall = 1'b0;
    logic [31:0] tx_prev_data = '0;
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (tx_prev_stall) check("R10 tx hold", {31'd0, tx_bus_valid} == 32'd1 ? tx_bus_data : 32'hDEAD_BEEF, tx_prev_data);
            if (tx_bus_valid && tx_bus_ready) tx_got.push_back(tx_bus_data);
            if (rx_word_valid && rx_word_ready) rx_got.push_back(rx_word_data);
        end
        tx_prev_stall = rst_n && tx_bus_valid && !tx_bus_ready;
        tx_prev_data  = tx_bus_data;
    end

    task automatic tx_put(input logic [23:0] w);
        @(negedge clk);
        tx_word_valid = 1'b1;
        tx_word_data  = w;
        #1;
        while (!tx_word_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        tx_word_valid = 1'b0;
    endtask

    task automatic rx_put(input logic [31:0] b);
        @(negedge clk);
        rx_bus_valid = 1'b1;
        rx_bus_data  = b;
        #1;
        while (!rx_bus_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        rx_bus_valid = 1'b0;
    endtask

    task automatic drain();
        tx_rdy_mode = 0;
        rx_rdy_mode = 0;
        repeat (8) @(negedge clk);
    endtask

    task automatic compare_queues(input string tag);
        check({tag, " tx count"}, tx_got.size(), tx_exp.size());
        check({tag, " rx count"}, rx_got.size(), rx_exp.size());
        while (tx_got.size() > 0 && tx_exp.size() > 0) check({tag, " tx word"}, tx_got.pop_front(), tx_exp.pop_front());
        while (rx_got.size() > 0 && rx_exp.size() > 0) check({tag, " rx word"}, {8'h00, rx_got.pop_front()}, {8'h00, rx_exp.pop_front()});
        tx_got.delete(); tx_exp.delete(); rx_got.delete(); rx_exp.delete();
    endtask

    // format write; expect_f is the code expected afterwards
    task automatic set_fmt(input logic [1:0] f, input logic [1:0] expect_f);
        @(negedge clk);
        cfg_wr  = 1'b1;
        cfg_fmt = f;
        #1;
        check("R8 readies low during write", {30'd0, tx_word_ready, rx_bus_ready}, 32'd0);
        @(posedge clk); #1;
        cfg_wr = 1'b0;
        @(negedge clk);
        check("R8/R9 format code", {30'd0, fmt_cur}, {30'd0, expect_f});
    endtask

    task automatic random_mode(input logic [1:0] f);
        set_fmt(f, f);
        tx_rdy_mode = 1;
        rx_rdy_mode = 1;
        fork
            begin
                for (int i = 0; i < 40; i += 2) begin
                    logic [23:0] a, b;
                    a = (i == 0) ? 24'h800000 : 24'($urandom);
                    b = (i == 0) ? 24'h7FFFFF : (i == 2) ? 24'hFFFFFF : 24'($urandom);
                    if (f == 2'd0) tx_exp.push_back(pack_out(a, b));
                    else begin tx_exp.push_back(fmt_out(f, a)); tx_exp.push_back(fmt_out(f, b)); end
                    tx_put(a);
                    tx_put(b);
                end
            end
            begin
                for (int i = 0; i < 30; i++) begin
                    logic [31:0] b;
                    b = (i == 0) ? 32'hFFFF_0001 : (i == 1) ? 32'h0000_FFFF : $urandom;
                    rx_exp.push_back(fmt_in(f, b, 1'b0));
                    if (f == 2'd0) rx_exp.push_back(fmt_in(f, b, 1'b1));
                    rx_put(b);
                end
            end
        join
        drain();
        case (f)
            2'd0: compare_queues("R2/R6/R10 fmt0");
            2'd1: compare_queues("R3/R7/R10 fmt1");
            2'd2: compare_queues("R4/R7/R10 fmt2");
            default: compare_queues("R5/R7/R10 fmt3");
        endcase
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 fmt", {30'd0, fmt_cur}, 32'd0);
        check("R1 err", {31'd0, fmt_err}, 32'd0);
        check("R1 valids", {30'd0, tx_bus_valid, rx_word_valid}, 32'd0);
        check("R1 readies", {30'd0, tx_word_ready, rx_bus_ready}, 32'd3);

        // R8: write while empty
        set_fmt(2'd1, 2'd1);

        // R11 + R3: outbound latency, format 1
        @(negedge clk);
        tx_word_valid = 1'b1;
        tx_word_data  = 24'h80_0001;
        #1;
        check("R11 tx not yet valid", {31'd0, tx_bus_valid}, 32'd0);
        @(posedge clk); #1;
        tx_word_valid = 1'b0;
        @(negedge clk);
        check("R11 tx valid next cycle", {31'd0, tx_bus_valid}, 32'd1);
        check("R3 zero extend", tx_bus_data, 32'h0080_0001);
        tx_exp.push_back(32'h0080_0001);

        // R11 + R7 + R10: inbound latency and hold, format 1
        rx_rdy_mode = 2;
        @(negedge clk);
        rx_bus_valid = 1'b1;
        rx_bus_data  = 32'hAABB_CCDD;
        #1;
        check("R11 rx not yet valid", {31'd0, rx_word_valid}, 32'd0);
        @(posedge clk); #1;
        rx_bus_valid = 1'b0;
        @(negedge clk);
        #3;
        check("R11 rx valid next cycle", {31'd0, rx_word_valid}, 32'd1);
        check("R7 low 24 bits", {8'h00, rx_word_data}, 32'h00BB_CCDD);
        repeat (3) @(negedge clk);
        #3;
        check("R10 rx held valid", {31'd0, rx_word_valid}, 32'd1);
        check("R10 rx held data", {8'h00, rx_word_data}, 32'h00BB_CCDD);
        rx_exp.push_back(24'hBB_CCDD);
        drain();
        compare_queues("R11 directed");

        random_mode(2'd0);
        random_mode(2'd1);
        random_mode(2'd2);
        random_mode(2'd3);

        // R9: half-filled pack blocks a format write
        set_fmt(2'd0, 2'd0);
        tx_put(24'h12_3456);
        repeat (2) @(negedge clk);
        check("R2 no bus word after one half", {31'd0, tx_bus_valid}, 32'd0);
        set_fmt(2'd2, 2'd0);
        check("R9 err set", {31'd0, fmt_err}, 32'd1);
        tx_exp.push_back(32'hBEEF_3456);
        tx_put(24'hAA_BEEF);

        // R9: held inbound word blocks a format write
        rx_rdy_mode = 2;
        rx_exp.push_back(24'h00_5678);
        rx_exp.push_back(24'h00_1234);
        rx_put(32'h1234_5678);
        set_fmt(2'd1, 2'd0);
        drain();
        compare_queues("R9 busy");

        // R9: flag stays set through an accepted write
        set_fmt(2'd3, 2'd3);
        check("R9 err sticky", {31'd0, fmt_err}, 32'd1);
        check("R5 quick left align", fmt_out(2'd3, 24'hFFFFFF), 32'hFFFF_FF00);

        finish_run();
    end
endmodule